// File: doc/BRIEF.md
# Warm-Reboot Configuration Command Sequencer

This block makes an FPGA reload itself from a different bitstream without a power cycle. It drives the 16-bit internal configuration port of the device. After a single start pulse, it plays a fixed command script into that port. The script synchronises the port and then loads four general registers. Two of these hold the multiboot image address and two hold the fallback image address. The script then writes the reboot opcode into the command register and closes with a no-op word. The two image addresses and the two opcode fields come from input ports. They are captured when the start pulse is accepted.

The port runs on a slow clock that the block produces from the system clock by a configurable divider. Data, chip enable and write strobe change only in the system cycle just before a rising edge of the port clock. Before any word reaches the port, the bits within each of its bytes are mirrored. A busy input from the port stalls the script on the current word. A one-cycle done pulse marks the end of the script.

Top module: `warm_reboot_seq`

## Requirements
- R1: After a synchronous reset, and for as long as no script runs, `port_ce_n_o` and `port_wr_n_o` are 1. `done_o` and `port_clk_o` are 0, and `port_data_o` is 0xFFFF.
- R2: `port_clk_o` is the system clock divided by DIV_RATIO. It is low for the first DIV_RATIO/2 cycles after reset and high for the next DIV_RATIO/2 cycles, and the pattern repeats.
- R3: `port_data_o`, `port_ce_n_o` and `port_wr_n_o` change only at the system edge that falls exactly one system cycle before a rising edge of `port_clk_o`.
- R4: A script is 14 words in this order: 0xFFFF, 0xAA99, 0x5566, 0x3261, boot address[15:0], 0x3281, {boot opcode, boot address[23:16]}, 0x32A1, fallback address[15:0], 0x32C1, {fallback opcode, fallback address[23:16]}, 0x30A1, 0x000E, 0x2000. These values are given before the byte mirroring of R6.
- R5: Each header word is 3'b001 in bits [15:13], the operation in bits [12:11] (2'b10 for a write), the register number in bits [10:5] and the word count in bits [4:0]. The register numbers are 0x13, 0x14, 0x15 and 0x16 for the four general registers and 0x05 for the command register. The no-op 0x2000 uses operation 2'b00.
- R6: Bit k of each byte of `port_data_o` carries bit 7-k of the same byte of the script word.
- R7: If `busy_i` is 1 at a word-update edge while a script runs, the word on the port is held. The script moves on only at an update edge where `busy_i` is 0.
- R8: `port_ce_n_o` and `port_wr_n_o` are always equal. Both go low when the first word is presented and both return high at the update edge after the last word is accepted.
- R9: A start pulse is ignored while a script is pending or running, so exactly one script is played per accepted start.
- R10: `done_o` is high for exactly one system cycle. That cycle directly follows the update edge at which the last word is accepted and chip enable returns high.
- R11: The address and opcode inputs are sampled in the cycle the start pulse is accepted. Later changes to them do not alter the running script.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start pulse requesting a reboot script |
| boot_addr_i | input | ADDR_W | Multiboot image start address |
| fall_addr_i | input | ADDR_W | Fallback image start address |
| boot_op_i | input | 32-ADDR_W | Opcode field placed above the multiboot address high bits |
| fall_op_i | input | 32-ADDR_W | Opcode field placed above the fallback address high bits |
| busy_i | input | 1 | Busy flag returned by the configuration port |
| port_clk_o | output | 1 | Divided clock for the configuration port |
| port_ce_n_o | output | 1 | Active-low chip enable |
| port_wr_n_o | output | 1 | Active-low write strobe |
| port_data_o | output | 16 | Byte-mirrored data word |
| done_o | output | 1 | One-cycle pulse when the script has finished |

## Verification
The bench uses the default DIV_RATIO of 8 and ADDR_W of 24. At these values the three-bit divider wraps through all eight phases. Each high-address word carries a full 8-bit opcode, so every bit of both bytes passes through the mirror. With a 14-word script and eight cycles per word, a complete run takes about 120 cycles. This leaves room for busy stalls that fall on several different update edges, for a restart attempt in the middle of a run, and for inputs that are scrambled after the start pulse.

// File: rtl/reboot_seq_pkg.sv
package reboot_seq_pkg;

  localparam int SCRIPT_LEN = 14;
  localparam int IDX_W      = 4;

  typedef enum logic [1:0] {
    SEQ_IDLE  = 2'd0,
    SEQ_ARMED = 2'd1,
    SEQ_RUN   = 2'd2
  } seq_state_t;

  localparam logic [1:0] PKT_OP_NOP = 2'b00;
  localparam logic [1:0] PKT_OP_WR  = 2'b10;

  localparam logic [5:0] REG_CMD  = 6'h05;
  localparam logic [5:0] REG_GEN1 = 6'h13;
  localparam logic [5:0] REG_GEN2 = 6'h14;
  localparam logic [5:0] REG_GEN3 = 6'h15;
  localparam logic [5:0] REG_GEN4 = 6'h16;

  localparam logic [15:0] WORD_DUMMY  = 16'hFFFF;
  localparam logic [15:0] WORD_SYNC_A = 16'hAA99;
  localparam logic [15:0] WORD_SYNC_B = 16'h5566;
  localparam logic [15:0] CMD_REBOOT  = 16'h000E;

  // Type-1 packet header: fixed prefix, operation, register, word count
  function automatic logic [15:0] type1_hdr(input logic [1:0] op,
                                            input logic [5:0] regsel,
                                            input logic [4:0] count);
    return {3'b001, op, regsel, count};
  endfunction

endpackage

// File: rtl/port_div.sv
module port_div #(
  parameter int DIV_RATIO = 8
) (
  input  logic clk,
  input  logic rst,
  output logic port_clk_o,
  output logic update_o
);
  localparam int HALF = DIV_RATIO / 2;
  localparam int CW   = (DIV_RATIO > 2) ? $clog2(DIV_RATIO) : 1;

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_nxt;

  always_comb begin
    if (cnt_q == CW'(DIV_RATIO - 1)) cnt_nxt = '0;
    else                             cnt_nxt = cnt_q + 1'b1;
  end

  // Update strobe: the edge that lands one cycle before the port clock rises
  assign update_o = (cnt_q == CW'(HALF - 2));

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q      <= '0;
      port_clk_o <= 1'b0;
    end else begin
      cnt_q      <= cnt_nxt;
      port_clk_o <= (cnt_nxt >= CW'(HALF));
    end
  end
endmodule

// File: rtl/script_rom.sv
module script_rom
  import reboot_seq_pkg::*;
#(
  parameter int ADDR_W = 24
) (
  input  logic [IDX_W-1:0]  idx_i,
  input  logic [ADDR_W-1:0] boot_addr_i,
  input  logic [ADDR_W-1:0] fall_addr_i,
  input  logic [31-ADDR_W:0] boot_op_i,
  input  logic [31-ADDR_W:0] fall_op_i,
  output logic [15:0]       word_o
);
  localparam logic [15:0] NOOP = type1_hdr(PKT_OP_NOP, 6'h00, 5'd0);

  always_comb begin
    case (idx_i)
      4'd0:    word_o = WORD_DUMMY;
      4'd1:    word_o = WORD_SYNC_A;
      4'd2:    word_o = WORD_SYNC_B;
      4'd3:    word_o = type1_hdr(PKT_OP_WR, REG_GEN1, 5'd1);
      4'd4:    word_o = boot_addr_i[15:0];
      4'd5:    word_o = type1_hdr(PKT_OP_WR, REG_GEN2, 5'd1);
      4'd6:    word_o = {boot_op_i, boot_addr_i[ADDR_W-1:16]};
      4'd7:    word_o = type1_hdr(PKT_OP_WR, REG_GEN3, 5'd1);
      4'd8:    word_o = fall_addr_i[15:0];
      4'd9:    word_o = type1_hdr(PKT_OP_WR, REG_GEN4, 5'd1);
      4'd10:   word_o = {fall_op_i, fall_addr_i[ADDR_W-1:16]};
      4'd11:   word_o = type1_hdr(PKT_OP_WR, REG_CMD, 5'd1);
      4'd12:   word_o = CMD_REBOOT;
      default: word_o = NOOP;
    endcase
  end
endmodule

// File: rtl/byte_mirror.sv
module byte_mirror #(
  parameter int BYTES = 2
) (
  input  logic [8*BYTES-1:0] din,
  output logic [8*BYTES-1:0] dout
);
  for (genvar b = 0; b < BYTES; b++) begin : g_byte
    for (genvar i = 0; i < 8; i++) begin : g_bit
      assign dout[8*b + i] = din[8*b + 7 - i];
    end
  end
endmodule

// File: rtl/warm_reboot_seq.sv
module warm_reboot_seq
  import reboot_seq_pkg::*;
#(
  parameter int DIV_RATIO = 8,
  parameter int ADDR_W    = 24
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] boot_addr_i,
  input  logic [ADDR_W-1:0] fall_addr_i,
  input  logic [31-ADDR_W:0] boot_op_i,
  input  logic [31-ADDR_W:0] fall_op_i,
  input  logic              busy_i,
  output logic              port_clk_o,
  output logic              port_ce_n_o,
  output logic              port_wr_n_o,
  output logic [15:0]       port_data_o,
  output logic              done_o
);
  localparam int OP_W = 32 - ADDR_W;
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(SCRIPT_LEN - 1);

  seq_state_t        state_q;
  logic [IDX_W-1:0]  idx_q;
  logic [IDX_W-1:0]  idx_sel;
  logic [ADDR_W-1:0] boot_addr_q, fall_addr_q;
  logic [OP_W-1:0]   boot_op_q, fall_op_q;
  logic              update;
  logic [15:0]       raw_word, mir_word;

  port_div #(.DIV_RATIO(DIV_RATIO)) u_div (
    .clk        (clk),
    .rst        (rst),
    .port_clk_o (port_clk_o),
    .update_o   (update)
  );

  // Word that goes out next: slot 0 when launching, else the following slot
  assign idx_sel = (state_q == SEQ_RUN) ? idx_q + 1'b1 : '0;

  script_rom #(.ADDR_W(ADDR_W)) u_rom (
    .idx_i       (idx_sel),
    .boot_addr_i (boot_addr_q),
    .fall_addr_i (fall_addr_q),
    .boot_op_i   (boot_op_q),
    .fall_op_i   (fall_op_q),
    .word_o      (raw_word)
  );

  byte_mirror #(.BYTES(2)) u_mirror (
    .din  (raw_word),
    .dout (mir_word)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q     <= SEQ_IDLE;
      idx_q       <= '0;
      boot_addr_q <= '0;
      fall_addr_q <= '0;
      boot_op_q   <= '0;
      fall_op_q   <= '0;
      port_ce_n_o <= 1'b1;
      port_wr_n_o <= 1'b1;
      port_data_o <= 16'hFFFF;
      done_o      <= 1'b0;
    end else begin
      done_o <= 1'b0;
      case (state_q)
        SEQ_IDLE: begin
          if (start_i) begin
            boot_addr_q <= boot_addr_i;
            fall_addr_q <= fall_addr_i;
            boot_op_q   <= boot_op_i;
            fall_op_q   <= fall_op_i;
            state_q     <= SEQ_ARMED;
          end
        end
        SEQ_ARMED: begin
          if (update) begin
            idx_q       <= '0;
            port_data_o <= mir_word;
            port_ce_n_o <= 1'b0;
            port_wr_n_o <= 1'b0;
            state_q     <= SEQ_RUN;
          end
        end
        SEQ_RUN: begin
          if (update && !busy_i) begin
            if (idx_q == LAST_IDX) begin
              port_ce_n_o <= 1'b1;
              port_wr_n_o <= 1'b1;
              done_o      <= 1'b1;
              state_q     <= SEQ_IDLE;
            end else begin
              idx_q       <= idx_sel;
              port_data_o <= mir_word;
            end
          end
        end
        default: begin
          state_q     <= SEQ_IDLE;
          port_ce_n_o <= 1'b1;
          port_wr_n_o <= 1'b1;
        end
      endcase
    end
  end
endmodule

// File: rtl/reboot_seq_chk.sv
module reboot_seq_chk (
  input logic        clk,
  input logic        rst,
  input logic        port_clk_o,
  input logic        port_ce_n_o,
  input logic        port_wr_n_o,
  input logic [15:0] port_data_o,
  input logic        done_o
);
  // R8
  ce_wr_lock_chk: assert property (@(posedge clk) disable iff (rst)
    port_ce_n_o == port_wr_n_o);

  // R3
  data_edge_chk: assert property (@(posedge clk) disable iff (rst)
    (port_data_o != $past(port_data_o)) |=> $rose(port_clk_o));

  // R3
  enable_edge_chk: assert property (@(posedge clk) disable iff (rst)
    (port_ce_n_o != $past(port_ce_n_o)) |=> $rose(port_clk_o));

  // R10
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);

  // R10
  done_close_chk: assert property (@(posedge clk) disable iff (rst)
    done_o |-> (port_ce_n_o && !$past(port_ce_n_o)));
endmodule

bind warm_reboot_seq reboot_seq_chk u_chk (
  .clk         (clk),
  .rst         (rst),
  .port_clk_o  (port_clk_o),
  .port_ce_n_o (port_ce_n_o),
  .port_wr_n_o (port_wr_n_o),
  .port_data_o (port_data_o),
  .done_o      (done_o)
);

// File: tb/tb_warm_reboot_seq.sv
module tb_warm_reboot_seq;
  localparam int DIV  = 8;
  localparam int HALF = DIV / 2;
  localparam int AW   = 24;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start_i = 1'b0;
  logic [23:0] boot_addr_i = '0, fall_addr_i = '0;
  logic [7:0]  boot_op_i = '0, fall_op_i = '0;
  logic        busy_i = 1'b0;
  logic        port_clk_o, port_ce_n_o, port_wr_n_o, done_o;
  logic [15:0] port_data_o;

  int checks = 0;
  int fails  = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  warm_reboot_seq #(.DIV_RATIO(DIV), .ADDR_W(AW)) dut (
    .clk(clk), .rst(rst), .start_i(start_i),
    .boot_addr_i(boot_addr_i), .fall_addr_i(fall_addr_i),
    .boot_op_i(boot_op_i), .fall_op_i(fall_op_i), .busy_i(busy_i),
    .port_clk_o(port_clk_o), .port_ce_n_o(port_ce_n_o),
    .port_wr_n_o(port_wr_n_o), .port_data_o(port_data_o), .done_o(done_o)
  );

  task automatic check(input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] mir(input logic [15:0] w);
    logic [15:0] r;
    for (int b = 0; b < 2; b++)
      for (int i = 0; i < 8; i++) r[8*b + i] = w[8*b + 7 - i];
    return r;
  endfunction

  // Script from the requirement text (R4, R5)
  function automatic logic [15:0] script(input int k, input logic [23:0] ba,
      input logic [23:0] fa, input logic [7:0] bo, input logic [7:0] fo);
    case (k)
      0: return 16'hFFFF;   1: return 16'hAA99;  2: return 16'h5566;
      3: return 16'h3261;   4: return ba[15:0];  5: return 16'h3281;
      6: return {bo, ba[23:16]};                 7: return 16'h32A1;
      8: return fa[15:0];   9: return 16'h32C1;
      10: return {fo, fa[23:16]};                11: return 16'h30A1;
      12: return 16'h000E;  default: return 16'h2000;
    endcase
  endfunction

  // Behavioural reference model
  int          ph;
  bit          m_clk, m_ce, m_done, m_run, m_pend;
  int          m_pos;
  logic [15:0] m_data;
  logic [15:0] q[$];

  always @(posedge clk) begin
    bit pre, idle;
    if (rst) begin
      ph = 0; m_clk = 0; m_ce = 1; m_done = 0; m_run = 0; m_pend = 0;
      m_pos = 0; m_data = 16'hFFFF;
    end else begin
      idle = !m_run && !m_pend;
      pre = (ph == HALF - 2);
      ph = (ph + 1) % DIV;
      m_clk = (ph >= HALF);
      m_done = 0;
      if (pre) begin
        if (m_run) begin
          if (!busy_i) begin
            if (m_pos == 13) begin
              m_run = 0; m_ce = 1; m_done = 1;
            end else begin
              m_pos++;
              m_data = mir(q[m_pos]);
            end
          end
        end else if (m_pend) begin
          m_pend = 0; m_run = 1; m_pos = 0; m_ce = 0;
          m_data = mir(q[0]);
        end
      end
      if (start_i && idle) begin
        m_pend = 1;
        q.delete();
        for (int k = 0; k < 14; k++)
          q.push_back(script(k, boot_addr_i, fall_addr_i, boot_op_i, fall_op_i));
      end
    end
  end

  always @(negedge clk) begin
    if (!rst && !finished) begin
      check("R2 port clock", port_clk_o, m_clk);
      check("R8 chip enable", port_ce_n_o, m_ce);
      check("R8 write strobe", port_wr_n_o, m_ce);
      check("R4/R6/R7 data", port_data_o, m_data);
      check("R10 done", done_o, m_done);
    end
  end

  task automatic run_seq(input logic [23:0] ba, input logic [23:0] fa,
                         input logic [7:0] bo, input logic [7:0] fo,
                         input bit stall, input bit restart, input bit scramble);
    logic [15:0] got[0:31];
    int n = 0, dones = 0, after = 0;
    bit prev_clk;
    @(negedge clk);
    boot_addr_i = ba; fall_addr_i = fa; boot_op_i = bo; fall_op_i = fo;
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    if (scramble) begin
      boot_addr_i = ~ba; fall_addr_i = ~fa; boot_op_i = ~bo; fall_op_i = ~fo;
    end
    prev_clk = port_clk_o;
    for (int cyc = 0; cyc < 3000; cyc++) begin
      @(negedge clk);
      if (port_clk_o && !prev_clk && !port_ce_n_o && !stall && n < 32) begin
        got[n] = port_data_o;
        n++;
      end
      prev_clk = port_clk_o;
      if (done_o) dones++;
      if (dones > 0) after++;
      start_i = (restart && cyc == 60);
      busy_i  = stall && ((cyc % 11) < 4);
      if (after > 40) break;
    end
    start_i = 1'b0;
    busy_i  = 1'b0;
    // R10 one pulse per run; R9 the restart did not launch a second script
    check("R10 done pulse count", dones, 1);
    check("R9 idle after run", port_ce_n_o, 1'b1);
    if (!stall) begin
      check("R4 word count", n, 14);
      for (int k = 0; k < 14 && k < n; k++) begin
        if (k == 3 || k == 5 || k == 7 || k == 9 || k == 11)
          check("R5 header word", got[k], mir(script(k, ba, fa, bo, fo)));
        else
          check("R6/R11 script word", got[k], mir(script(k, ba, fa, bo, fo)));
      end
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    check("R1 ce_n", port_ce_n_o, 1'b1);
    check("R1 wr_n", port_wr_n_o, 1'b1);
    check("R1 done", done_o, 1'b0);
    check("R1 data", port_data_o, 16'hFFFF);
    check("R1 port clk", port_clk_o, 1'b0);
    repeat (10) @(negedge clk);
    check("R1 idle ce_n", port_ce_n_o, 1'b1);
    // R4 R5 R6 plain run
    run_seq(24'h123456, 24'hABCDEF, 8'h0B, 8'hC3, 0, 0, 0);
    // R7 busy stalls
    run_seq(24'h00FF01, 24'h80A5C0, 8'hF0, 8'h81, 1, 0, 0);
    // R9 start ignored mid-run
    run_seq(24'h5A5A5A, 24'h0F0F0F, 8'h3C, 8'h99, 0, 1, 0);
    // R11 inputs scrambled after start
    run_seq(24'hFEDCBA, 24'h010203, 8'h7E, 8'h24, 0, 0, 1);
    repeat (20) @(negedge clk);
    finished = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #(8 * 150000);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      finished = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule